// File: doc/BRIEF.md
# Bidirectional Latch-Register Bus Transceiver

This block moves words between two buses, called A and B, one path per direction. Each path has one storage element with three behaviours. It can be transparent, so the output follows the input. It can hold its contents. It can capture the input on the falling edge of its own capture strobe. Each direction has its own pass enable, capture strobe and drive enable. The A-to-B drive enable is active high. The B-to-A drive enable is active low, so the two directions use opposite polarities.

There are no true tri-states. Each bus is split into an input word, a qualifier that says the input is valid, an output word and a drive-enable flag. The integration layer builds the pad or bus mux from these signals. A keeper register on each input stands in for bus-hold. When the qualifier drops, the path sees the last word that was presented while the qualifier was high.

The capture strobes are ordinary inputs. They are sampled on the system clock `clk`, and a falling edge is detected between two samples. This keeps the whole block in a single clock domain. The data interface has no valid/ready handshake and no back-pressure: words are never queued. A path either passes its input, holds its stored word, or overwrites the stored word. A downstream consumer that is not ready only has to leave the capture strobe still.

Top module: `xcvr_bidir`

## Requirements
- R1: While a path's pass enable is high, its output word equals its effective input word in the same cycle.
- R2: While a path's pass enable is low and its capture strobe keeps the same level at consecutive `clk` edges, the output keeps its stored word whatever the input does.
- R3: While the pass enable is low, a strobe sampled high at one `clk` edge and low at the next loads the effective input at that second edge, and the output shows the new word from then on.
- R4: `b_oe` equals `ab_drive` (1 = B driven) whenever reset is released.
- R5: `a_oe` equals the inverse of `ba_drive_n` (`ba_drive_n` = 0 means A driven) whenever reset is released.
- R6: When an input qualifier is low, the effective input of that bus is the word registered at the last `clk` edge at which the qualifier was high. The keeper resets to zero.
- R7: While `rst_n` is low, both drive enables are 0, and every storage element and keeper clears to zero.
- R8: `contention` is 1 exactly when both drive enables are 1. Each output word still carries its own path's value.
- R9: A strobe rising edge (sampled low, then high) with the pass enable low leaves the stored word unchanged.
- R10: When the pass enable falls, the output holds the effective input that was present at the last `clk` edge while the enable was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples strobes and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | WIDTH | Word presented on the A bus |
| a_in_vld | input | 1 | A input is being driven (keeper follows it) |
| b_in | input | WIDTH | Word presented on the B bus |
| b_in_vld | input | 1 | B input is being driven |
| ab_pass | input | 1 | A-to-B transparent enable |
| ab_strobe | input | 1 | A-to-B capture strobe, falling edge loads |
| ab_drive | input | 1 | A-to-B drive enable, active high |
| ba_pass | input | 1 | B-to-A transparent enable |
| ba_strobe | input | 1 | B-to-A capture strobe, falling edge loads |
| ba_drive_n | input | 1 | B-to-A drive enable, active low |
| a_out | output | WIDTH | Word driven toward the A bus |
| a_oe | output | 1 | A bus drive enable |
| b_out | output | WIDTH | Word driven toward the B bus |
| b_oe | output | 1 | B bus drive enable |
| contention | output | 1 | Both directions drive at once |

## Verification
The bench builds the block with WIDTH set to 8. At that width every vector names a full word in two hex digits, and each pattern reaches every bit lane. A single table walks the A-to-B path through pass, hold, strobe rise, strobe fall, drive toggling and keeper hand-over, in an order where each step depends on the state left by the step before. Directed steps then cover the mirrored B-to-A path with its inverted enable, simultaneous drive, and a reset asserted mid-run with storage already loaded.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_PASS    = 2'd1,
    MODE_CAPTURE = 2'd2
  } path_mode_e;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_AB  = 0;
  localparam int unsigned DIR_BA  = 1;
endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int unsigned WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] bus_d,
  input  logic             bus_vld,
  output logic [WIDTH-1:0] bus_eff
);
  logic [WIDTH-1:0] kept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       kept <= '0;
    else if (bus_vld) kept <= bus_d;
  end

  assign bus_eff = bus_vld ? bus_d : kept;

  // R6: the kept word moves only while the bus is driven
  a_r6_keep_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_vld |=> $stable(kept));
  a_r6_keep_track: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld |=> kept == $past(bus_d));
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             pass,
  input  logic             strobe,
  output logic [WIDTH-1:0] dout
);
  logic             strobe_q;
  logic [WIDTH-1:0] store;
  path_mode_e       mode;

  always_comb begin
    if (pass)                    mode = MODE_PASS;
    else if (strobe_q && !strobe) mode = MODE_CAPTURE;
    else                         mode = MODE_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      store    <= '0;
    end else begin
      strobe_q <= strobe;
      if (mode != MODE_HOLD) store <= din;
    end
  end

  assign dout = (mode == MODE_PASS) ? din : store;

  // R3: a falling strobe with the pass enable low loads the input
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && strobe_q && !strobe) |=> store == $past(din));
  // R9: a rising strobe leaves the stored word alone
  a_r9_rise_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && !strobe_q && strobe) |=> $stable(store));
  // R2: a steady strobe with the pass enable low holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && (strobe_q == strobe)) |=> $stable(store));
  // R10: while transparent the store tracks the input for the close
  a_r10_close: assert property (@(posedge clk) disable iff (!rst_n)
    pass |=> store == $past(din));
endmodule

// File: rtl/xcvr_bidir.sv
module xcvr_bidir
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic             a_in_vld,
  input  logic [WIDTH-1:0] b_in,
  input  logic             b_in_vld,
  input  logic             ab_pass,
  input  logic             ab_strobe,
  input  logic             ab_drive,
  input  logic             ba_pass,
  input  logic             ba_strobe,
  input  logic             ba_drive_n,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic             contention
);
  logic [WIDTH-1:0] src_d   [NUM_DIR];
  logic             src_vld [NUM_DIR];
  logic [WIDTH-1:0] src_eff [NUM_DIR];
  logic [WIDTH-1:0] dst_d   [NUM_DIR];
  logic             pass_v  [NUM_DIR];
  logic             strb_v  [NUM_DIR];

  assign src_d[DIR_AB]   = a_in;
  assign src_vld[DIR_AB] = a_in_vld;
  assign pass_v[DIR_AB]  = ab_pass;
  assign strb_v[DIR_AB]  = ab_strobe;
  assign src_d[DIR_BA]   = b_in;
  assign src_vld[DIR_BA] = b_in_vld;
  assign pass_v[DIR_BA]  = ba_pass;
  assign strb_v[DIR_BA]  = ba_strobe;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_keeper #(.WIDTH(WIDTH)) keeper_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_d   (src_d[d]),
      .bus_vld (src_vld[d]),
      .bus_eff (src_eff[d])
    );
    xcvr_path #(.WIDTH(WIDTH)) path_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (src_eff[d]),
      .pass   (pass_v[d]),
      .strobe (strb_v[d]),
      .dout   (dst_d[d])
    );
  end

  assign b_out      = dst_d[DIR_AB];
  assign a_out      = dst_d[DIR_BA];
  assign b_oe       = rst_n & ab_drive;
  assign a_oe       = rst_n & ~ba_drive_n;
  assign contention = b_oe & a_oe;

  // R7: no bus is driven while reset is held
  always_comb begin
    if (rst_n === 1'b0) begin
      a_r7_quiet_in_reset: assert (!a_oe && !b_oe && !contention);
    end
  end
endmodule

// File: tb/xcvr_bidir_tb_top.sv
module xcvr_bidir_tb_top;
  localparam int W = 8;
  localparam int NV = 12;
  // {a_in, a_vld, ab_pass, ab_strobe, ab_drive, exp_b_out, exp_b_oe}
  localparam logic [20:0] TAB [NV] = '{
    {8'h11, 1'b1, 1'b1, 1'b0, 1'b1, 8'h11, 1'b1},  // R1 pass
    {8'h22, 1'b1, 1'b1, 1'b0, 1'b1, 8'h22, 1'b1},  // R1 pass
    {8'h33, 1'b1, 1'b0, 1'b0, 1'b1, 8'h22, 1'b1},  // R10 close holds 22
    {8'h44, 1'b1, 1'b0, 1'b1, 1'b1, 8'h22, 1'b1},  // R9 rise ignored
    {8'h55, 1'b1, 1'b0, 1'b0, 1'b1, 8'h55, 1'b1},  // R3 fall loads
    {8'h66, 1'b1, 1'b0, 1'b0, 1'b1, 8'h55, 1'b1},  // R2 steady holds
    {8'h66, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0},  // R4 drive off
    {8'h77, 1'b1, 1'b1, 1'b0, 1'b1, 8'h77, 1'b1},  // R4 drive on, pass
    {8'h99, 1'b0, 1'b1, 1'b0, 1'b1, 8'h77, 1'b1},  // R6 keeper
    {8'hAA, 1'b0, 1'b0, 1'b1, 1'b1, 8'h77, 1'b1},  // R2 hold
    {8'hAA, 1'b1, 1'b0, 1'b0, 1'b1, 8'hAA, 1'b1},  // R3 fall loads
    {8'hBB, 1'b0, 1'b1, 1'b0, 1'b1, 8'hAA, 1'b1}   // R6 keeper in pass
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic a_in_vld = 1'b0, b_in_vld = 1'b0;
  logic ab_pass = 1'b0, ab_strobe = 1'b0, ab_drive = 1'b1;
  logic ba_pass = 1'b0, ba_strobe = 1'b0, ba_drive_n = 1'b0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe, contention;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  xcvr_bidir #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_in_vld(a_in_vld), .b_in(b_in), .b_in_vld(b_in_vld),
    .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_drive(ab_drive),
    .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
    .contention(contention)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R7: reset state with both drives requested
    #2;
    chk("R7 drives off in reset", {29'd0, a_oe, b_oe, contention}, 32'd0);
    chk("R7 outputs zero in reset", {16'd0, a_out, b_out}, 32'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ab_drive = 1'b0; ba_drive_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {a_in, a_in_vld, ab_pass, ab_strobe, ab_drive} = TAB[i][20:9];
      step();
      chk($sformatf("R1-table row %0d b_out", i), {24'd0, b_out}, {24'd0, TAB[i][8:1]});
      chk($sformatf("R4 row %0d b_oe", i), {31'd0, b_oe}, {31'd0, TAB[i][0]});
    end

    // R5 / R8: B-to-A pass while both drive
    @(negedge clk);
    b_in = 8'h5A; b_in_vld = 1'b1; ba_pass = 1'b1; ba_drive_n = 1'b0;
    step();
    chk("R1 a_out pass", {24'd0, a_out}, 32'h5A);
    chk("R5 a_oe active low", {31'd0, a_oe}, 32'd1);
    chk("R8 contention", {31'd0, contention}, 32'd1);
    chk("R8 b_out own value", {24'd0, b_out}, 32'hAA);

    @(negedge clk);
    ba_drive_n = 1'b1;
    step();
    chk("R5 a_oe released", {30'd0, a_oe, contention}, 32'd0);

    @(negedge clk);
    ba_pass = 1'b0; ba_strobe = 1'b1; b_in = 8'hC3;
    step();
    chk("R2 B-to-A hold", {24'd0, a_out}, 32'h5A);

    @(negedge clk);
    ba_strobe = 1'b0;
    step();
    chk("R3 B-to-A capture", {24'd0, a_out}, 32'hC3);

    // R7: mid-run reset clears loaded storage
    @(negedge clk);
    ab_pass = 1'b0; ab_drive = 1'b1; ba_drive_n = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R7 drives off mid-run", {29'd0, a_oe, b_oe, contention}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R7 storage cleared", {16'd0, a_out, b_out}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule